// File: doc/BRIEF.md
# Float to 32-bit Integer Converter

This block turns one single- or double-precision binary floating-point operand into a signed 32-bit two's-complement integer. It always truncates toward zero. A caller presents the operand, a precision select and two trap-enable bits, then pulses a start strobe. A fixed number of cycles later the block pulses a done strobe. Along with it come the integer, an invalid flag, an inexact flag and a write-enable that says whether the integer may be stored.

Inside, a short control counter steps a radix-4 right shifter that aligns the significand to the integer point. The shifter gathers the bits it drops into a sticky bit. A final stage then applies sign, range and exception rules.

Operands that cannot be represented are flagged invalid: NaN, infinity, and values that are too large in magnitude. When invalid does not trap, the result saturates according to the operand's sign bit. When an exception whose trap is enabled occurs, the destination is left unwritten.

Top module: `f2i_convert`

## Requirements
- R1: An in-range operand yields its integer part, truncated toward zero, as a 32-bit two's-complement value. An exact conversion raises neither flag.
- R2: If any nonzero fraction bit is discarded from an in-range operand, the inexact flag is raised.
- R3: A zero of either sign yields 0 with no flags. A subnormal, or a normal operand of magnitude below 1.0, yields 0 with inexact raised.
- R4: An operand whose exponent field is all ones (infinity or NaN) raises invalid.
- R5: A positive operand of 2147483648.0 or more raises invalid. A negative operand of -2147483649.0 or less raises invalid. Operands above -2147483649.0 and up to -2147483648.0 yield 32'h80000000 without invalid, with inexact if they have a fraction.
- R6: When invalid is raised and not trapped, the result is 32'h7FFFFFFF if the operand sign bit is 0 and 32'h80000000 if it is 1, NaNs included.
- R7: Invalid and inexact are never reported together. Invalid takes precedence.
- R8: With trap_invalid_en set and invalid raised, or with trap_inexact_en set and inexact raised, result_wr stays 0 and result keeps its earlier value. The flags are still reported with done. A trap enable whose exception did not occur has no effect.
- R9: After reset, done, result_wr, result and both flags are 0. done and result_wr are valid for exactly one cycle, on the fourth rising edge after the edge that accepts start.
- R10: A start that arrives while a conversion is in progress is ignored. No extra done pulse is produced and the running result is not changed.
- R11: When is_double is 0, the operand is taken from operand[31:0] in single format (sign bit 31, 8-bit exponent, 23-bit fraction) and operand[63:32] is ignored. When is_double is 1, the operand uses all 64 bits in double format (sign bit 63, 11-bit exponent, 52-bit fraction).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a conversion (accepted only when idle) |
| is_double | input | 1 | 1 = double format, 0 = single format in low word |
| operand | input | 64 | Floating-point operand |
| trap_invalid_en | input | 1 | Invalid exception traps (suppresses write) |
| trap_inexact_en | input | 1 | Inexact exception traps (suppresses write) |
| done | output | 1 | One-cycle completion strobe |
| result_wr | output | 1 | Result written this cycle (no trapped exception) |
| result | output | 32 | Signed integer result (holds when not written) |
| flag_invalid | output | 1 | Invalid exception of the last conversion |
| flag_inexact | output | 1 | Inexact exception of the last conversion |

## Verification
Every result, flag and write strobe is due on the fourth rising edge after the edge that samples start. Each scenario task drives its inputs on a falling edge and then counts falling edges until done is seen. It requires that count to be exactly five, and it reads result, flags and result_wr at that same falling edge, half a period after they were registered. The busy scenario counts done pulses over a longer window. The trap scenarios compare result against the value left by the previous conversion, read in the cycle done is high.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

    localparam int MAG_W   = 64;
    localparam int INT_W   = 32;
    localparam int SH_W    = 6;
    localparam int DIG_W   = 2;
    localparam int NSTEP   = SH_W / DIG_W;
    localparam int IDX_W   = (NSTEP > 1) ? $clog2(NSTEP) : 1;
    localparam int CNT_W   = $clog2(NSTEP + 1);

    localparam int SP_EXP  = 8;
    localparam int SP_FRAC = 23;
    localparam int SP_BIAS = 127;
    localparam int DP_EXP  = 11;
    localparam int DP_FRAC = 52;
    localparam int DP_BIAS = 1023;

    localparam int SP_PAD  = MAG_W - 1 - SP_FRAC;
    localparam int DP_PAD  = MAG_W - 1 - DP_FRAC;

    typedef enum logic [1:0] {
        K_ZERO  = 2'd0,
        K_TINY  = 2'd1,
        K_BAD   = 2'd2,
        K_SHIFT = 2'd3
    } kind_e;

    typedef struct packed {
        logic             sign;
        kind_e            kind;
        logic             top_exp;
        logic [SH_W-1:0]  sh;
        logic [MAG_W-1:0] mag;
    } unpacked_t;

    typedef struct packed {
        logic [INT_W-1:0] value;
        logic             invalid;
        logic             inexact;
    } outcome_t;

    function automatic unpacked_t classify(
        input logic             sign,
        input logic             exp_ones,
        input logic             exp_zero,
        input logic             frac_nz,
        input int               unb_exp,
        input logic [MAG_W-1:0] mag
    );
        unpacked_t u;
        u.sign    = sign;
        u.mag     = mag;
        u.top_exp = 1'b0;
        u.sh      = SH_W'(MAG_W - 1);
        if (exp_ones) begin
            u.kind = K_BAD;
        end else if (exp_zero) begin
            u.kind = frac_nz ? K_TINY : K_ZERO;
        end else if (unb_exp < 0) begin
            u.kind = K_TINY;
        end else if (unb_exp > INT_W - 1) begin
            u.kind = K_BAD;
        end else begin
            u.kind    = K_SHIFT;
            u.sh      = SH_W'(MAG_W - 1 - unb_exp);
            u.top_exp = (unb_exp == INT_W - 1);
        end
        return u;
    endfunction

    function automatic logic [INT_W-1:0] saturate(input logic sign);
        return sign ? {1'b1, {(INT_W-1){1'b0}}} : {1'b0, {(INT_W-1){1'b1}}};
    endfunction

endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
    import f2i_pkg::*;
(
    input  logic             is_double,
    input  logic [MAG_W-1:0] operand,
    output unpacked_t        fields
);

    logic [SP_EXP-1:0]  sp_e;
    logic [SP_FRAC-1:0] sp_f;
    logic [DP_EXP-1:0]  dp_e;
    logic [DP_FRAC-1:0] dp_f;
    unpacked_t          sp_u;
    unpacked_t          dp_u;

    always_comb begin
        sp_e = operand[SP_EXP+SP_FRAC-1:SP_FRAC];
        sp_f = operand[SP_FRAC-1:0];
        dp_e = operand[DP_EXP+DP_FRAC-1:DP_FRAC];
        dp_f = operand[DP_FRAC-1:0];

        sp_u = classify(operand[SP_EXP+SP_FRAC], &sp_e, ~|sp_e, |sp_f,
                        int'(sp_e) - SP_BIAS, {1'b1, sp_f, {SP_PAD{1'b0}}});
        dp_u = classify(operand[DP_EXP+DP_FRAC], &dp_e, ~|dp_e, |dp_f,
                        int'(dp_e) - DP_BIAS, {1'b1, dp_f, {DP_PAD{1'b0}}});

        fields = is_double ? dp_u : sp_u;
    end

endmodule

// File: rtl/f2i_ctrl.sv
module f2i_ctrl
    import f2i_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             load,
    output logic             step_en,
    output logic [IDX_W-1:0] step_idx,
    output logic             finish
);

    logic             busy;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        load     = start && !busy;
        step_en  = busy && (cnt < CNT_W'(NSTEP));
        finish   = busy && (cnt == CNT_W'(NSTEP));
        step_idx = cnt[IDX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (load) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (finish) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt  <= cnt + 1'b1;
        end
    end

    assert_load_enters_busy_R9: assert property (@(posedge clk) disable iff (rst)
        load |=> (busy && cnt == '0));

    assert_busy_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && !finish) |=> busy);

    assert_finish_ends_R9: assert property (@(posedge clk) disable iff (rst)
        finish |=> !busy);

endmodule

// File: rtl/f2i_align.sv
module f2i_align
    import f2i_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [MAG_W-1:0] mag_in,
    input  logic [SH_W-1:0]  sh_in,
    input  logic             step_en,
    input  logic [IDX_W-1:0] step_idx,
    output logic [MAG_W-1:0] mag_out,
    output logic             sticky
);

    logic [SH_W-1:0]  sh_r;
    logic [MAG_W-1:0] cand_mag  [NSTEP];
    logic             cand_lost [NSTEP];
    logic [MAG_W-1:0] sel_mag;
    logic             sel_lost;

    for (genvar i = 0; i < NSTEP; i++) begin : g_step
        logic [SH_W-1:0] amt;
        assign amt          = SH_W'(sh_r[i*DIG_W +: DIG_W]) << (i * DIG_W);
        assign cand_mag[i]  = mag_out >> amt;
        assign cand_lost[i] = |(mag_out & ~({MAG_W{1'b1}} << amt));
    end

    always_comb begin
        sel_mag  = mag_out;
        sel_lost = 1'b0;
        for (int k = 0; k < NSTEP; k++) begin
            if (step_idx == IDX_W'(k)) begin
                sel_mag  = cand_mag[k];
                sel_lost = cand_lost[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_r    <= '0;
            mag_out <= '0;
            sticky  <= 1'b0;
        end else if (load) begin
            sh_r    <= sh_in;
            mag_out <= mag_in;
            sticky  <= 1'b0;
        end else if (step_en) begin
            mag_out <= sel_mag;
            sticky  <= sticky | sel_lost;
        end
    end

    assert_shift_never_grows_R1: assert property (@(posedge clk) disable iff (rst)
        step_en && !load |=> (mag_out <= $past(mag_out)));

    assert_sticky_keeps_R2: assert property (@(posedge clk) disable iff (rst)
        (step_en && !load && sticky) |=> sticky);

endmodule

// File: rtl/f2i_convert.sv
module f2i_convert
    import f2i_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              is_double,
    input  logic [MAG_W-1:0]  operand,
    input  logic              trap_invalid_en,
    input  logic              trap_inexact_en,
    output logic              done,
    output logic              result_wr,
    output logic [INT_W-1:0]  result,
    output logic              flag_invalid,
    output logic              flag_inexact
);

    unpacked_t        fields;
    logic             load;
    logic             step_en;
    logic [IDX_W-1:0] step_idx;
    logic             finish;
    logic [MAG_W-1:0] aligned;
    logic             sticky;

    logic             c_sign;
    kind_e            c_kind;
    logic             c_top;
    logic             c_tinv;
    logic             c_tinx;

    outcome_t         fin;
    logic             trapped;
    logic [INT_W-1:0] trunc;

    f2i_unpack u_unpack (
        .is_double (is_double),
        .operand   (operand),
        .fields    (fields)
    );

    f2i_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .load     (load),
        .step_en  (step_en),
        .step_idx (step_idx),
        .finish   (finish)
    );

    f2i_align u_align (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .mag_in   (fields.mag),
        .sh_in    (fields.sh),
        .step_en  (step_en),
        .step_idx (step_idx),
        .mag_out  (aligned),
        .sticky   (sticky)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            c_sign <= 1'b0;
            c_kind <= K_ZERO;
            c_top  <= 1'b0;
            c_tinv <= 1'b0;
            c_tinx <= 1'b0;
        end else if (load) begin
            c_sign <= fields.sign;
            c_kind <= fields.kind;
            c_top  <= fields.top_exp;
            c_tinv <= trap_invalid_en;
            c_tinx <= trap_inexact_en;
        end
    end

    always_comb begin
        trunc = aligned[INT_W-1:0];
        fin   = '{value: '0, invalid: 1'b0, inexact: 1'b0};
        unique case (c_kind)
            K_ZERO: fin = '{value: '0, invalid: 1'b0, inexact: 1'b0};
            K_TINY: fin = '{value: '0, invalid: 1'b0, inexact: 1'b1};
            K_BAD:  fin = '{value: saturate(c_sign), invalid: 1'b1, inexact: 1'b0};
            K_SHIFT: begin
                if (c_top && (!c_sign || |trunc[INT_W-2:0])) begin
                    fin = '{value: saturate(c_sign), invalid: 1'b1, inexact: 1'b0};
                end else begin
                    fin.value   = c_sign ? (~trunc + 1'b1) : trunc;
                    fin.invalid = 1'b0;
                    fin.inexact = sticky;
                end
            end
            default: fin = '{value: '0, invalid: 1'b0, inexact: 1'b0};
        endcase
        trapped = (fin.invalid && c_tinv) || (fin.inexact && c_tinx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done         <= 1'b0;
            result_wr    <= 1'b0;
            result       <= '0;
            flag_invalid <= 1'b0;
            flag_inexact <= 1'b0;
        end else if (finish) begin
            done         <= 1'b1;
            result_wr    <= !trapped;
            flag_invalid <= fin.invalid;
            flag_inexact <= fin.inexact;
            if (!trapped) begin
                result <= fin.value;
            end
        end else begin
            done      <= 1'b0;
            result_wr <= 1'b0;
        end
    end

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_wr_with_done_R8: assert property (@(posedge clk) disable iff (rst)
        result_wr |-> done);

    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !(flag_invalid && flag_inexact));

    assert_result_held_R8: assert property (@(posedge clk) disable iff (rst)
        !result_wr |-> $stable(result));

    assert_saturate_value_R6: assert property (@(posedge clk) disable iff (rst)
        (done && flag_invalid && result_wr) |->
            (result == 32'h7FFF_FFFF || result == 32'h8000_0000));

    assert_aligned_fits_R1: assert property (@(posedge clk) disable iff (rst)
        (finish && c_kind == K_SHIFT) |-> (aligned[MAG_W-1:INT_W] == '0));

endmodule

// File: tb/test_f2i_convert.sv
module test_f2i_convert;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        is_double = 1'b0;
    logic [63:0] operand = '0;
    logic        trap_invalid_en = 1'b0;
    logic        trap_inexact_en = 1'b0;
    logic        done;
    logic        result_wr;
    logic [31:0] result;
    logic        flag_invalid;
    logic        flag_inexact;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    f2i_convert i_f2i_convert (
        .clk             (clk),
        .rst             (rst),
        .start           (start),
        .is_double       (is_double),
        .operand         (operand),
        .trap_invalid_en (trap_invalid_en),
        .trap_inexact_en (trap_inexact_en),
        .done            (done),
        .result_wr       (result_wr),
        .result          (result),
        .flag_invalid    (flag_invalid),
        .flag_inexact    (flag_inexact)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Run one conversion; expects done on the 5th falling edge after drive (R9).
    task automatic convert(input logic [63:0] op, input logic dbl,
                           input logic tinv, input logic tinx,
                           input logic [31:0] exp_res, input logic exp_inv,
                           input logic exp_inx, input logic exp_wr,
                           input string tag);
        int waited = 0;
        @(negedge clk);
        operand = op; is_double = dbl;
        trap_invalid_en = tinv; trap_inexact_en = tinx;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        operand = 64'hA5A5_A5A5_A5A5_A5A5;
        waited = 1;
        while (!done && waited < 20) begin
            @(negedge clk);
            waited++;
        end
        check(waited == 5, {tag, "/R9"}, "done latency", 32'(waited), 32'd5);
        check(result === exp_res, tag, "result", result, exp_res);
        check(flag_invalid === exp_inv, tag, "invalid", 32'(flag_invalid), 32'(exp_inv));
        check(flag_inexact === exp_inx, tag, "inexact", 32'(flag_inexact), 32'(exp_inx));
        check(result_wr === exp_wr, tag, "result_wr", 32'(result_wr), 32'(exp_wr));
        @(negedge clk);
        check(done === 1'b0, {tag, "/R9"}, "done one cycle", 32'(done), 32'd0);
    endtask

    task automatic t_reset;
        check(done === 1'b0, "R9", "reset done", 32'(done), 0);
        check(result_wr === 1'b0, "R9", "reset wr", 32'(result_wr), 0);
        check(result === 32'd0, "R9", "reset result", result, 0);
        check(flag_invalid === 1'b0 && flag_inexact === 1'b0, "R9", "reset flags",
              {30'd0, flag_invalid, flag_inexact}, 0);
    endtask

    task automatic t_in_range;
        convert(64'h3F80_0000, 1'b0, 0, 0, 32'd1, 0, 0, 1, "R1");
        convert(64'h4EFF_FFFF, 1'b0, 0, 0, 32'h7FFF_FF80, 0, 0, 1, "R1");
        convert(64'h41DF_FFFF_FFC0_0000, 1'b1, 0, 0, 32'h7FFF_FFFF, 0, 0, 1, "R1");
        convert(64'hC01C_0000_0000_0000, 1'b1, 0, 0, 32'hFFFF_FFF9, 0, 0, 1, "R1");
    endtask

    task automatic t_inexact;
        convert(64'hC020_0000, 1'b0, 0, 0, 32'hFFFF_FFFE, 0, 1, 1, "R2");
        convert(64'h400E_0000_0000_0000, 1'b1, 0, 0, 32'd3, 0, 1, 1, "R2");
    endtask

    task automatic t_small;
        convert(64'h0000_0000, 1'b0, 0, 0, 32'd0, 0, 0, 1, "R3");
        convert(64'h8000_0000_0000_0000, 1'b1, 0, 0, 32'd0, 0, 0, 1, "R3");
        convert(64'h0000_0001, 1'b0, 0, 0, 32'd0, 0, 1, 1, "R3");
        convert(64'h0000_0000_0000_0001, 1'b1, 0, 0, 32'd0, 0, 1, 1, "R3");
        convert(64'h3F40_0000, 1'b0, 0, 0, 32'd0, 0, 1, 1, "R3");
    endtask

    task automatic t_special;
        convert(64'h7F80_0000, 1'b0, 0, 0, 32'h7FFF_FFFF, 1, 0, 1, "R4");
        convert(64'hFF80_0000, 1'b0, 0, 0, 32'h8000_0000, 1, 0, 1, "R4");
        convert(64'h7FF8_0000_0000_0000, 1'b1, 0, 0, 32'h7FFF_FFFF, 1, 0, 1, "R6");
        convert(64'hFFC0_0000, 1'b0, 0, 0, 32'h8000_0000, 1, 0, 1, "R6");
    endtask

    task automatic t_range;
        convert(64'h4F00_0000, 1'b0, 0, 0, 32'h7FFF_FFFF, 1, 0, 1, "R5");
        convert(64'h41E0_0000_0000_0000, 1'b1, 0, 0, 32'h7FFF_FFFF, 1, 0, 1, "R5");
        convert(64'hCF00_0000, 1'b0, 0, 0, 32'h8000_0000, 0, 0, 1, "R5");
        convert(64'hC1E0_0000_0010_0000, 1'b1, 0, 0, 32'h8000_0000, 0, 1, 1, "R5");
        convert(64'hC1E0_0000_0020_0000, 1'b1, 0, 0, 32'h8000_0000, 1, 0, 1, "R5");
        // fraction present but invalid: inexact must stay low
        convert(64'h41F0_0000_0000_8000, 1'b1, 0, 0, 32'h7FFF_FFFF, 1, 0, 1, "R7");
    endtask

    task automatic t_traps;
        convert(64'h40A0_0000, 1'b0, 0, 0, 32'd5, 0, 0, 1, "R8");
        convert(64'h4020_0000, 1'b0, 0, 1, 32'd5, 0, 1, 0, "R8");
        convert(64'h7FC0_0000, 1'b0, 1, 0, 32'd5, 1, 0, 0, "R8");
        convert(64'h4110_0000, 1'b0, 0, 1, 32'd9, 0, 0, 1, "R8");
        convert(64'h4020_0000, 1'b0, 1, 0, 32'd2, 0, 1, 1, "R8");
    endtask

    task automatic t_precision;
        convert({32'hDEAD_BEEF, 32'h3F80_0000}, 1'b0, 0, 0, 32'd1, 0, 0, 1, "R11");
        convert(64'h3FF0_0000_0000_0000, 1'b1, 0, 0, 32'd1, 0, 0, 1, "R11");
    endtask

    task automatic t_busy;
        int pulses = 0;
        @(negedge clk);
        operand = 64'h4040_0000; is_double = 1'b0;   // 3.0
        trap_invalid_en = 0; trap_inexact_en = 0;
        start = 1'b1;
        @(negedge clk);
        operand = 64'h4110_0000;                       // 9.0 while busy
        @(negedge clk);
        operand = 64'h7F80_0000;                       // infinity while busy
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 10; k++) begin
            if (done) begin
                pulses++;
                check(result === 32'd3, "R10", "busy result", result, 32'd3);
                check(flag_invalid === 1'b0, "R10", "busy invalid", 32'(flag_invalid), 0);
            end
            @(negedge clk);
        end
        check(pulses == 1, "R10", "done pulses", 32'(pulses), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_in_range;
        t_inexact;
        t_small;
        t_special;
        t_range;
        t_traps;
        t_precision;
        t_busy;
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule